// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer

This block is the digital control core of a successive-approximation sampling converter. Two active-low control lines, a chip select and a read/convert strobe, are combined by a logical OR. A conversion begins when that combined signal falls, which happens on the fall of whichever line goes low last. Either line may fall first. When a conversion starts, an active-low busy flag drops and a conversion interval of fixed length is timed. When that interval ends, the result is moved into an output holding register and busy rises again. An acquisition interval of fixed length then follows, and the next conversion may only start after it.

The analog sample-and-hold and the comparator are not part of the block. The code for each conversion comes from a value-source input. The block takes that value at the clock edge where busy returns high, so the holding register keeps the previous result for the whole of a conversion. A one-cycle pulse marks each new result. A flag marks the first result after reset as not valid. A power-down input prevents any conversion from starting. A start request that arrives while a conversion or an acquisition is under way is dropped, and a sticky overrun flag records it. The interval lengths are clock-cycle counts. For example, 2.2 µs of conversion and 1.8 µs of acquisition at 100 MHz give 220 and 180 cycles.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, busy_n is 1, result is 0, and result_valid, first_result and overrun are 0.
- R2: A start request is a 1-to-0 transition of (cs_n OR rc_n) seen between two rising clock edges. It does not matter which line falls first. If both lines fall together, exactly one conversion starts. Taking a line high never starts a conversion.
- R3: busy_n goes to 0 at the clock edge where an accepted start is seen. It stays 0 for exactly CONV_CYCLES clock cycles.
- R4: result takes the value of conv_value at the edge where busy_n returns to 1. At every other edge result keeps its value, so during a conversion it shows the previous result.
- R5: result_valid is 1 for exactly one cycle for each completed conversion, and only in the cycle where busy_n has just returned to 1.
- R6: After busy_n rises, an acquisition interval of ACQ_CYCLES cycles follows. A start request seen at the last edge of that interval is dropped. A start request seen at the next edge is accepted.
- R7: A start request seen during a conversion or an acquisition starts nothing and sets overrun to 1. overrun stays 1 until reset.
- R8: While pwr_down is 1, a start request in the idle phase starts nothing and does not set overrun. result keeps its value.
- R9: first_result is 1 together with the first result loaded after reset. It is 0 for every later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, acting as power-up |
| cs_n | input | 1 | Active-low chip select |
| rc_n | input | 1 | Active-low read/convert strobe |
| pwr_down | input | 1 | When 1, conversions are inhibited |
| conv_value | input | RES_W | Code from the value-source stub |
| busy_n | output | 1 | Low while a conversion runs |
| result | output | RES_W | Output holding register |
| result_valid | output | 1 | One-cycle pulse when a new result is loaded |
| first_result | output | 1 | Marks the held result as the invalid first one after reset |
| overrun | output | 1 | Sticky flag: a start request was dropped because the block was busy |

## Verification
The bound checker tests these properties on every clock cycle:
- busy_n stays low for exactly CONV_CYCLES cycles each time it falls.
- result_valid occurs only together with a rise of busy_n and lasts one cycle.
- result stays constant except when result_valid is high.
- overrun, once set, stays set until reset.
- no conversion starts while pwr_down is held high.

Some behaviours can only be shown by the bench scenarios:
- a start works whether cs_n or rc_n falls first.
- a simultaneous fall of both lines gives only one conversion.
- the acquisition boundary is exact to the cycle.
- the value loaded matches the source value.
- first_result is set only on the first result after each reset.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    // Default width of a conversion code.
    localparam int unsigned RESULT_W = 16;

    // Phases of one conversion cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_ACQ  = 2'd2
    } phase_e;

    // Per-cycle decisions of the phase controller.
    typedef struct packed {
        logic   tmr_load;
        logic   capture;
        logic   dropped;
        phase_e next;
    } ctl_t;

    // Width of a down-counter that must hold values 0 .. n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // The larger of two interval lengths.
    function automatic int unsigned max_len(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/start_detect.sv
// Detects the fall of the ORed active-low control lines.
module start_detect (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rc_n,
    output logic start
);
    logic ored;
    logic ored_q;

    assign ored = cs_n | rc_n;

    always_ff @(posedge clk) begin
        if (rst) ored_q <= 1'b1;
        else     ored_q <= ored;
    end

    assign start = ored_q & ~ored;
endmodule

// File: rtl/phase_timer.sv
// Loadable down-counter that reports when it has reached zero.
module phase_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/result_hold.sv
// Output holding register, with a marker for the first result after reset.
module result_hold #(
    parameter int unsigned RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] dout,
    output logic             first_out
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout      <= '0;
            first_out <= 1'b0;
            seen_q    <= 1'b0;
        end else if (capture) begin
            dout      <= din;
            first_out <= ~seen_q;
            seen_q    <= 1'b1;
        end
    end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int unsigned RES_W       = RESULT_W,
    parameter int unsigned CONV_CYCLES = 220,
    parameter int unsigned ACQ_CYCLES  = 180
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rc_n,
    input  logic             pwr_down,
    input  logic [RES_W-1:0] conv_value,
    output logic             busy_n,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic             first_result,
    output logic             overrun
);
    localparam int unsigned CW = cnt_width(max_len(CONV_CYCLES, ACQ_CYCLES));
    localparam logic [CW-1:0] CONV_LOAD = CW'(CONV_CYCLES - 1);
    localparam logic [CW-1:0] ACQ_LOAD  = CW'(ACQ_CYCLES - 1);

    logic          start;
    logic          tmr_zero;
    logic [CW-1:0] load_val;
    phase_e        phase_q;
    ctl_t          ctl;

    start_detect u_start (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .rc_n  (rc_n),
        .start (start)
    );

    phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.tmr_load),
        .load_val (load_val),
        .zero     (tmr_zero)
    );

    result_hold #(.RES_W(RES_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .capture   (ctl.capture),
        .din       (conv_value),
        .dout      (result),
        .first_out (first_result)
    );

    always_comb begin
        ctl          = '0;
        ctl.next     = phase_q;
        load_val     = CONV_LOAD;
        unique case (phase_q)
            PH_IDLE: begin
                if (start && !pwr_down) begin
                    ctl.next     = PH_CONV;
                    ctl.tmr_load = 1'b1;
                    load_val     = CONV_LOAD;
                end
            end
            PH_CONV: begin
                ctl.dropped = start;
                if (tmr_zero) begin
                    ctl.next     = PH_ACQ;
                    ctl.capture  = 1'b1;
                    ctl.tmr_load = 1'b1;
                    load_val     = ACQ_LOAD;
                end
            end
            PH_ACQ: begin
                ctl.dropped = start;
                if (tmr_zero) ctl.next = PH_IDLE;
            end
            default: ctl.next = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            busy_n       <= 1'b1;
            result_valid <= 1'b0;
            overrun      <= 1'b0;
        end else begin
            phase_q      <= ctl.next;
            busy_n       <= (ctl.next != PH_CONV);
            result_valid <= ctl.capture;
            if (ctl.dropped) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
    parameter int unsigned RES_W       = 16,
    parameter int unsigned CONV_CYCLES = 220
) (
    input logic             clk,
    input logic             rst,
    input logic             pwr_down,
    input logic             busy_n,
    input logic [RES_W-1:0] result,
    input logic             result_valid,
    input logic             first_result,
    input logic             overrun
);
    localparam int unsigned LW = $clog2(CONV_CYCLES + 2);

    logic [LW-1:0] busy_lo_q;

    always_ff @(posedge clk) begin
        if (rst)         busy_lo_q <= '0;
        else if (busy_n) busy_lo_q <= '0;
        else             busy_lo_q <= busy_lo_q + 1'b1;
    end

    // R3: low window of busy is exactly the conversion length
    p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (busy_lo_q == LW'(CONV_CYCLES)));

    // R5: a new-result pulse accompanies every rise of busy and nothing else
    p_valid_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $rose(busy_n));
    p_rise_gives_valid_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> result_valid);
    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R4: holding register changes only with a new result
    p_result_held_r4: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

    // R7: overrun is sticky
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R8: no conversion begins while power-down is held
    p_pd_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && busy_n) |=> busy_n);

    // R9: the first-result marker only rises with a new result
    p_first_with_valid_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(first_result) |-> result_valid);
endmodule

bind conv_sequencer conv_sequencer_chk #(
    .RES_W       (RES_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_down     (pwr_down),
    .busy_n       (busy_n),
    .result       (result),
    .result_valid (result_valid),
    .first_result (first_result),
    .overrun      (overrun)
);

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
    localparam int unsigned W = 16;
    localparam int unsigned C = 22;
    localparam int unsigned A = 18;

    typedef struct packed {
        logic [W-1:0] code;
        logic         first;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         rc_n = 1'b1;
    logic         pwr_down = 1'b0;
    logic [W-1:0] conv_value = '0;
    logic         busy_n;
    logic [W-1:0] result;
    logic         result_valid;
    logic         first_result;
    logic         overrun;

    int   n_chk = 0;
    int   n_bad = 0;
    int   n_push = 0;
    int   n_pop = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    conv_sequencer #(.RES_W(W), .CONV_CYCLES(C), .ACQ_CYCLES(A)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rc_n(rc_n), .pwr_down(pwr_down),
        .conv_value(conv_value), .busy_n(busy_n), .result(result),
        .result_valid(result_valid), .first_result(first_result), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic [W-1:0] code, input logic first);
        exp_t e;
        e.code  = code;
        e.first = first;
        sb_q.push_back(e);
        n_push++;
    endtask

    // mode 0: cs first, 1: rc first, 2: together
    task automatic fire(input int mode, input logic [W-1:0] val, input logic first);
        conv_value = val;
        push(val, first);
        if (mode == 0) begin
            cs_n = 1'b0; @(negedge clk); rc_n = 1'b0;
        end else if (mode == 1) begin
            rc_n = 1'b0; @(negedge clk); cs_n = 1'b0;
        end else begin
            cs_n = 1'b0; rc_n = 1'b0;
        end
        @(negedge clk);
        check(busy_n == 1'b0, "R2 start on second fall", busy_n, 0);
        cs_n = 1'b1; rc_n = 1'b1;
    endtask

    task automatic wait_done();
        repeat (C + A + 3) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard when the block reports a result
    logic prev_busy = 1'b1;
    int   lo_cnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            prev_busy <= 1'b1;
            lo_cnt    <= 0;
        end else begin
            if (result_valid && !(busy_n && !prev_busy))
                check(1'b0, "R5 pulse without busy rise", result_valid, 0);
            if (busy_n && !prev_busy) begin
                check(lo_cnt == C, "R3 busy low length", lo_cnt, C);
                check(result_valid == 1'b1, "R5 pulse at busy rise", result_valid, 1);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected conversion", result, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    n_pop++;
                    check(result == e.code, "R4 loaded value", result, e.code);
                    check(first_result == e.first, "R9 first marker", first_result, e.first);
                end
            end
            lo_cnt    <= busy_n ? 0 : lo_cnt + 1;
            prev_busy <= busy_n;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy_n == 1'b1, "R1 busy_n", busy_n, 1);
        check(result == '0, "R1 result", result, 0);
        check(result_valid == 1'b0, "R1 result_valid", result_valid, 0);
        check(first_result == 1'b0, "R1 first_result", first_result, 0);
        check(overrun == 1'b0, "R1 overrun", overrun, 0);

        // cs first; previous result visible during conversion (R4)
        fire(0, 16'hA5C3, 1'b1);
        repeat (5) @(negedge clk);
        check(result == '0, "R4 previous result during conversion", result, 0);
        wait_done();

        // rc first
        fire(1, 16'h1234, 1'b0);
        wait_done();
        check(first_result == 1'b0, "R9 later result unmarked", first_result, 0);

        // both together, plus a dropped request during conversion (R7)
        fire(2, 16'hFFFF, 1'b0);
        repeat (4) @(negedge clk);
        cs_n = 1'b0; rc_n = 1'b0;
        @(negedge clk);
        check(overrun == 1'b1, "R7 overrun set in conversion", overrun, 1);
        check(busy_n == 1'b0, "R7 conversion continues", busy_n, 0);
        cs_n = 1'b1; rc_n = 1'b1;
        wait_done();
        check(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
        check(result == 16'hFFFF, "R4 held after conversion", result, 16'hFFFF);

        // power-down blocks the start (R8)
        pwr_down = 1'b1;
        conv_value = 16'h0BAD;
        @(negedge clk);
        cs_n = 1'b0; rc_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy_n == 1'b1, "R8 no start in power-down", busy_n, 1);
        cs_n = 1'b1; rc_n = 1'b1;
        repeat (C + 3) @(negedge clk);
        check(result == 16'hFFFF, "R8 result kept", result, 16'hFFFF);
        pwr_down = 1'b0;
        @(negedge clk);

        // second reset clears overrun and first marker (R1, R7, R9)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(overrun == 1'b0, "R7 overrun cleared by reset", overrun, 0);
        check(result == '0, "R1 result after reset", result, 0);

        // acquisition boundary with cs_n held low (R6)
        cs_n = 1'b0;
        @(negedge clk);
        conv_value = 16'h0F0F;
        push(16'h0F0F, 1'b1);
        rc_n = 1'b0;
        @(negedge clk);
        check(busy_n == 1'b0, "R2 start with cs held low", busy_n, 0);
        rc_n = 1'b1;
        @(posedge busy_n);
        repeat (A) @(negedge clk);
        rc_n = 1'b0;
        @(negedge clk);
        check(busy_n == 1'b1, "R6 start at last acquisition edge dropped", busy_n, 1);
        check(overrun == 1'b1, "R7 overrun set in acquisition", overrun, 1);
        rc_n = 1'b1;
        @(negedge clk);
        conv_value = 16'h7001;
        push(16'h7001, 1'b0);
        rc_n = 1'b0;
        @(negedge clk);
        check(busy_n == 1'b0, "R6 start after acquisition accepted", busy_n, 0);
        rc_n = 1'b1;
        wait_done();
        cs_n = 1'b1;
        @(negedge clk);

        check(sb_q.size() == 0, "R5 all results delivered", sb_q.size(), 0);
        check(n_pop == n_push, "R5 result count", n_pop, n_push);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule